// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the main control decoder of a 32-bit processor that completes one instruction per clock. It reads the 6-bit opcode from the top of the instruction word and sets every datapath control for that instruction. These controls cover the destination register choice, the second ALU operand, the write-back source, the register and memory enables, the branch and jump qualifiers, the return-address link and a 2-bit ALU operation class. A second-level ALU decoder uses that class together with the function field. The block has no state. Its outputs follow the instruction word within the same cycle.

The decoder also produces the next-PC branch select. It combines the branch-equal and branch-not-equal qualifiers with the ALU zero flag, so a conditional branch is taken only when its condition holds. An opcode that is not in the supported set drives every control that could change machine state to its inactive value.

Top module: `sc_main_decode`

## Requirements
- R1: Opcode 000000 (register format) drives dst_sel_rd=1, alu_src_imm=0, wb_from_mem=0, reg_wr_en=1, mem_rd_en=0, mem_wr_en=0, br_if_eq=0, br_if_ne=0, jump_en=0, link_en=0 and alu_class=10.
- R2: Opcode 100011 (load word) drives dst_sel_rd=0, alu_src_imm=1, wb_from_mem=1, reg_wr_en=1, mem_rd_en=1 and alu_class=00. All other controls are 0.
- R3: Opcode 101011 (store word) drives alu_src_imm=1, mem_wr_en=1 and alu_class=00. All other controls are 0, including dst_sel_rd and wb_from_mem. The memory read and write enables are never both 1.
- R4: Opcode 000100 (branch if equal) drives br_if_eq=1 and alu_class=01. All other controls are 0.
- R5: Opcode 000101 (branch if not equal) drives br_if_ne=1 and alu_class=01. All other controls are 0.
- R6: Opcode 001000 (add immediate) drives alu_src_imm=1, reg_wr_en=1 and alu_class=00. All other controls are 0.
- R7: Opcode 000010 (jump) drives jump_en=1. All other controls are 0.
- R8: Opcode 000011 (jump and link) drives jump_en=1, link_en=1 and reg_wr_en=1. All other controls are 0. link_en is never 1 unless reg_wr_en and jump_en are also 1.
- R9: pc_br_sel equals (br_if_eq AND alu_zero) OR (br_if_ne AND NOT alu_zero). It is never 1 when both qualifiers are 0.
- R10: Any other opcode drives reg_wr_en, mem_wr_en, mem_rd_en, br_if_eq, br_if_ne, jump_en, link_en and pc_br_sel to 0 for either value of alu_zero. At most one of br_if_eq, br_if_ne and jump_en is 1 for any opcode.
- R11: Instruction bits below the opcode field (bits 25 to 0) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word; opcode in bits 31..26 |
| alu_zero | input | 1 | ALU result-is-zero flag |
| dst_sel_rd | output | 1 | 1 selects rd as destination register, 0 selects rt |
| alu_src_imm | output | 1 | 1 selects immediate as ALU operand B, 0 selects register |
| wb_from_mem | output | 1 | 1 writes back data memory output, 0 the ALU result |
| reg_wr_en | output | 1 | Register file write enable |
| mem_rd_en | output | 1 | Data memory read enable |
| mem_wr_en | output | 1 | Data memory write enable |
| br_if_eq | output | 1 | Branch qualifier taken on zero |
| br_if_ne | output | 1 | Branch qualifier taken on not zero |
| jump_en | output | 1 | Unconditional jump |
| link_en | output | 1 | Write return address into register 31 |
| alu_class | output | 2 | ALU operation class for the function-field decoder |
| pc_br_sel | output | 1 | Next-PC select for a taken conditional branch |

## Verification
The checker assumes that instr and alu_zero are driven to known 0/1 values whenever its comparisons evaluate. It also assumes the outputs are read only after the combinational paths settle. It makes no assumption about which opcodes occur, so its invariants must hold for legal and illegal codes alike. The bench changes the inputs just after a rising edge and reads the outputs at the following falling edge. It covers every supported opcode, a spread of unsupported ones and random-looking lower instruction bits, so all inputs are defined and settled wherever a check or an invariant looks.

// File: rtl/sc_ctl_pkg.sv
package sc_ctl_pkg;

   localparam int OPC_W      = 6;
   localparam int ALU_CLS_W  = 2;
   localparam int NUM_KINDS  = 8;

   typedef enum logic [3:0] {
      K_ILLEGAL = 4'd0,
      K_RTYPE   = 4'd1,
      K_LOAD    = 4'd2,
      K_STORE   = 4'd3,
      K_BEQ     = 4'd4,
      K_BNE     = 4'd5,
      K_ADDI    = 4'd6,
      K_JUMP    = 4'd7,
      K_JAL     = 4'd8
   } op_kind_e;

   // Opcode of kind (index + 1)
   localparam logic [OPC_W-1:0] OPC_TBL [NUM_KINDS] = '{
      6'b000000,  // register format
      6'b100011,  // load word
      6'b101011,  // store word
      6'b000100,  // branch if equal
      6'b000101,  // branch if not equal
      6'b001000,  // add immediate
      6'b000010,  // jump
      6'b000011   // jump and link
   };

   localparam logic [ALU_CLS_W-1:0] CLS_ADD  = 2'b00;
   localparam logic [ALU_CLS_W-1:0] CLS_SUB  = 2'b01;
   localparam logic [ALU_CLS_W-1:0] CLS_FUNC = 2'b10;

   typedef struct packed {
      logic                 dst_rd;
      logic                 src_imm;
      logic                 wb_mem;
      logic                 reg_wr;
      logic                 mem_rd;
      logic                 mem_wr;
      logic                 br_eq;
      logic                 br_ne;
      logic                 jump;
      logic                 link;
      logic [ALU_CLS_W-1:0] alu_cls;
   } ctl_t;

   localparam ctl_t CTL_IDLE = '{default: '0};

endpackage

// File: rtl/sc_op_classify.sv
module sc_op_classify
   import sc_ctl_pkg::*;
#(
   parameter int OP_W = OPC_W
) (
   input  logic [OP_W-1:0] op,
   output op_kind_e        kind
);

   if (OP_W != OPC_W) begin : g_bad_width
      $error("sc_op_classify: opcode width must match the table width");
   end

   logic [NUM_KINDS-1:0] hit;

   for (genvar gi = 0; gi < NUM_KINDS; gi++) begin : g_match
      assign hit[gi] = (op == OPC_TBL[gi]);
   end

   always_comb begin
      kind = K_ILLEGAL;
      for (int i = 0; i < NUM_KINDS; i++) begin
         if (hit[i]) kind = op_kind_e'(4'(i + 1));
      end
   end

endmodule

// File: rtl/sc_ctl_table.sv
module sc_ctl_table
   import sc_ctl_pkg::*;
(
   input  op_kind_e kind,
   output ctl_t     ctl
);

   always_comb begin
      ctl = CTL_IDLE;
      unique case (kind)
         K_RTYPE: begin
            ctl.dst_rd  = 1'b1;
            ctl.reg_wr  = 1'b1;
            ctl.alu_cls = CLS_FUNC;
         end
         K_LOAD: begin
            ctl.src_imm = 1'b1;
            ctl.wb_mem  = 1'b1;
            ctl.reg_wr  = 1'b1;
            ctl.mem_rd  = 1'b1;
            ctl.alu_cls = CLS_ADD;
         end
         K_STORE: begin
            ctl.src_imm = 1'b1;
            ctl.mem_wr  = 1'b1;
            ctl.alu_cls = CLS_ADD;
         end
         K_BEQ: begin
            ctl.br_eq   = 1'b1;
            ctl.alu_cls = CLS_SUB;
         end
         K_BNE: begin
            ctl.br_ne   = 1'b1;
            ctl.alu_cls = CLS_SUB;
         end
         K_ADDI: begin
            ctl.src_imm = 1'b1;
            ctl.reg_wr  = 1'b1;
            ctl.alu_cls = CLS_ADD;
         end
         K_JUMP: begin
            ctl.jump    = 1'b1;
         end
         K_JAL: begin
            ctl.jump    = 1'b1;
            ctl.link    = 1'b1;
            ctl.reg_wr  = 1'b1;
         end
         default: ctl = CTL_IDLE;
      endcase
   end

endmodule

// File: rtl/sc_pc_branch.sv
module sc_pc_branch (
   input  logic br_eq,
   input  logic br_ne,
   input  logic zero,
   output logic take
);

   logic eq_take;
   logic ne_take;

   assign eq_take = br_eq & zero;
   assign ne_take = br_ne & ~zero;
   assign take    = eq_take | ne_take;

endmodule

// File: rtl/sc_main_decode.sv
module sc_main_decode
   import sc_ctl_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int OP_W    = 6
) (
   input  logic                 [INSTR_W-1:0] instr,
   input  logic                               alu_zero,
   output logic                               dst_sel_rd,
   output logic                               alu_src_imm,
   output logic                               wb_from_mem,
   output logic                               reg_wr_en,
   output logic                               mem_rd_en,
   output logic                               mem_wr_en,
   output logic                               br_if_eq,
   output logic                               br_if_ne,
   output logic                               jump_en,
   output logic                               link_en,
   output logic                 [ALU_CLS_W-1:0] alu_class,
   output logic                               pc_br_sel
);

   localparam int OP_LSB = INSTR_W - OP_W;

   if (OP_LSB < 1) begin : g_bad_fields
      $error("sc_main_decode: opcode field leaves no operand bits");
   end

   logic [OP_W-1:0] op;
   op_kind_e        kind;
   ctl_t            ctl;
   logic            unused_low;

   assign op         = instr[INSTR_W-1:OP_LSB];
   assign unused_low = ^instr[OP_LSB-1:0];

   sc_op_classify #(.OP_W(OP_W)) u_classify (
      .op   (op),
      .kind (kind)
   );

   sc_ctl_table u_table (
      .kind (kind),
      .ctl  (ctl)
   );

   sc_pc_branch u_pcsel (
      .br_eq (ctl.br_eq),
      .br_ne (ctl.br_ne),
      .zero  (alu_zero),
      .take  (pc_br_sel)
   );

   assign dst_sel_rd  = ctl.dst_rd;
   assign alu_src_imm = ctl.src_imm;
   assign wb_from_mem = ctl.wb_mem;
   assign reg_wr_en   = ctl.reg_wr;
   assign mem_rd_en   = ctl.mem_rd;
   assign mem_wr_en   = ctl.mem_wr;
   assign br_if_eq    = ctl.br_eq;
   assign br_if_ne    = ctl.br_ne;
   assign jump_en     = ctl.jump;
   assign link_en     = ctl.link;
   assign alu_class   = ctl.alu_cls;

endmodule

// File: rtl/sc_main_decode_chk.sv
module sc_main_decode_chk (
   input logic       alu_zero,
   input logic       dst_sel_rd,
   input logic       alu_src_imm,
   input logic       wb_from_mem,
   input logic       reg_wr_en,
   input logic       mem_rd_en,
   input logic       mem_wr_en,
   input logic       br_if_eq,
   input logic       br_if_ne,
   input logic       jump_en,
   input logic       link_en,
   input logic [1:0] alu_class,
   input logic       pc_br_sel
);

   always_comb begin
      // R3
      mem_excl_chk: assert (!(mem_rd_en && mem_wr_en));
      // R8
      link_implies_chk: assert (!link_en || (reg_wr_en && jump_en));
      // R9
      pcsel_cause_chk: assert (!pc_br_sel || (br_if_eq && alu_zero) || (br_if_ne && !alu_zero));
      // R10
      flow_onehot_chk: assert ($onehot0({br_if_eq, br_if_ne, jump_en}));
      // R2
      wb_mem_load_chk: assert (!wb_from_mem || (mem_rd_en && reg_wr_en && alu_src_imm));
      // R1
      rd_dest_class_chk: assert (!dst_sel_rd || (alu_class == 2'b10 && !alu_src_imm));
   end

endmodule

bind sc_main_decode sc_main_decode_chk u_chk (.*);

// File: tb/tb_sc_main_decode.sv
module tb_sc_main_decode;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = '0;
   logic        alu_zero = 1'b0;
   logic        dst_sel_rd, alu_src_imm, wb_from_mem, reg_wr_en;
   logic        mem_rd_en, mem_wr_en, br_if_eq, br_if_ne;
   logic        jump_en, link_en, pc_br_sel;
   logic [1:0]  alu_class;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   sc_main_decode dut (
      .instr       (instr),
      .alu_zero    (alu_zero),
      .dst_sel_rd  (dst_sel_rd),
      .alu_src_imm (alu_src_imm),
      .wb_from_mem (wb_from_mem),
      .reg_wr_en   (reg_wr_en),
      .mem_rd_en   (mem_rd_en),
      .mem_wr_en   (mem_wr_en),
      .br_if_eq    (br_if_eq),
      .br_if_ne    (br_if_ne),
      .jump_en     (jump_en),
      .link_en     (link_en),
      .alu_class   (alu_class),
      .pc_br_sel   (pc_br_sel)
   );

   // Bit order: dst imm wbm regwr memrd memwr beq bne jmp link cls[1:0] pcsel
   function automatic logic [12:0] expect_for(input logic [5:0] op, input logic z);
      logic [11:0] c;
      logic        beq, bne;
      case (op)
         6'b000000: c = 12'b1001_0000_0010;
         6'b100011: c = 12'b0111_1000_0000;
         6'b101011: c = 12'b0100_0100_0000;
         6'b000100: c = 12'b0000_0010_0001;
         6'b000101: c = 12'b0000_0001_0001;
         6'b001000: c = 12'b0101_0000_0000;
         6'b000010: c = 12'b0000_0000_1000;
         6'b000011: c = 12'b0001_0000_1100;
         default:   c = 12'b0;
      endcase
      beq = c[5];
      bne = c[4];
      return {c, (beq & z) | (bne & ~z)};
   endfunction

   function automatic logic [12:0] observed();
      return {dst_sel_rd, alu_src_imm, wb_from_mem, reg_wr_en, mem_rd_en, mem_wr_en,
              br_if_eq, br_if_ne, jump_en, link_en, alu_class, pc_br_sel};
   endfunction

   task automatic apply_check(input string req, input logic [5:0] op,
                              input logic [25:0] low, input logic z);
      @(posedge clk);
      #0.5;
      instr    = {op, low};
      alu_zero = z;
      @(negedge clk);
      n_checks++;
      if (observed() !== expect_for(op, z)) begin
         n_fails++;
         $display("FAIL %s op=%b z=%b actual=%b expected=%b",
                  req, op, z, observed(), expect_for(op, z));
      end
   endtask

   task automatic t_reset_state();
      apply_check("R1", 6'b000000, 26'h0, 1'b0);
   endtask

   task automatic t_rtype();
      apply_check("R1", 6'b000000, 26'h0430820, 1'b0);
      apply_check("R1", 6'b000000, 26'h1a5f824, 1'b1);
   endtask

   task automatic t_load();
      apply_check("R2", 6'b100011, 26'h08c0010, 1'b0);
      apply_check("R2", 6'b100011, 26'h3ffffff, 1'b1);
   endtask

   task automatic t_store();
      apply_check("R3", 6'b101011, 26'h1234567, 1'b0);
      apply_check("R3", 6'b101011, 26'h0000004, 1'b1);
   endtask

   task automatic t_branch();
      apply_check("R4", 6'b000100, 26'h0110003, 1'b1);
      apply_check("R9", 6'b000100, 26'h0110003, 1'b0);
      apply_check("R5", 6'b000101, 26'h022fffe, 1'b0);
      apply_check("R9", 6'b000101, 26'h022fffe, 1'b1);
   endtask

   task automatic t_addi();
      apply_check("R6", 6'b001000, 26'h0a5ffff, 1'b0);
      apply_check("R6", 6'b001000, 26'h0000001, 1'b1);
   endtask

   task automatic t_jumps();
      apply_check("R7", 6'b000010, 26'h0100000, 1'b1);
      apply_check("R8", 6'b000011, 26'h0200040, 1'b0);
      apply_check("R8", 6'b000011, 26'h0200040, 1'b1);
   endtask

   task automatic t_illegal();
      logic [5:0] bad [6] = '{6'b111111, 6'b000001, 6'b010000, 6'b100100, 6'b001001, 6'b000110};
      for (int i = 0; i < 6; i++) begin
         apply_check("R10", bad[i], 26'h155aa55, 1'b0);
         apply_check("R10", bad[i], 26'h2aa55aa, 1'b1);
      end
   endtask

   task automatic t_low_bits();
      for (int i = 0; i < 4; i++) begin
         apply_check("R11", 6'b100011, 26'(32'h9e3779b9 * (i + 1)), i[0]);
         apply_check("R11", 6'b000101, 26'(32'h7f4a7c15 * (i + 3)), i[0]);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_reset_state();
      t_rtype();
      t_load();
      t_store();
      t_branch();
      t_addi();
      t_jumps();
      t_illegal();
      t_low_bits();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule